// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps a small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line holds a tag, one data word and a coherence state: Invalid, Shared (clean, possibly copied elsewhere) or Exclusive (the only copy, possibly dirty). Reads and writes from the local processor are served at once when the state allows it. Otherwise the controller issues a read-miss or write-miss transaction on the bus. Before it reuses a slot that holds dirty data, it first writes that data back.

At the same time the controller watches miss transactions that other caches put on the bus. Under the write-invalidate policy, a remote write miss removes the local copy. A remote read miss to a dirty local line makes the controller supply the data with a flush and demote the line to Shared. A remote write miss to a dirty local line also causes a flush, and the line is invalidated.

Only one miss can be outstanding at a time. The processor sees `cpu_busy` while a bus transaction is in flight, and it holds its request until `cpu_done` is high.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_busy` and `flush_valid` are low, and the first processor access to any address misses.
- R2: A processor read that misses issues bus command 2'b01 (read miss) with the request address. In the cycle `bus_gnt` is high, `cpu_done` is high and `cpu_rdata` equals `bus_rdata`. The line is then installed Shared.
- R3: A processor read to a Shared or Exclusive line with a matching tag completes in the request's first cycle with the stored word, and no bus transaction occurs.
- R4: A processor write to an Exclusive line with a matching tag completes in its first cycle with no bus transaction, stores the new word and leaves the line Exclusive.
- R5: A processor write to a Shared line with a matching tag issues bus command 2'b10 (write miss). On `bus_gnt` it completes, and the line becomes Exclusive holding the written word.
- R6: A processor write to an Invalid line, or to a clean line with another tag, issues a write miss and installs the line Exclusive with the written word.
- R7: A miss whose slot holds an Exclusive line with another tag first issues bus command 2'b11 (write-back). That transaction carries the victim's address and data, and the new miss follows after its grant. A clean victim is dropped without a write-back.
- R8: A snooped write miss (`snp_cmd` 2'b10) to a Shared line with a matching tag invalidates the line without a flush.
- R9: A snooped read miss (`snp_cmd` 2'b01) to an Exclusive line with a matching tag raises `flush_valid` in the next cycle with that address and the line's data. The line becomes Shared, so later reads hit and writes need a write miss.
- R10: A snooped write miss to an Exclusive line with a matching tag flushes in the next cycle like R9 and leaves the line Invalid.
- R11: A snoop whose tag differs, whose line is Invalid, or whose `snp_cmd` is 2'b00 or 2'b11 changes no line and raises no flush.
- R12: From the cycle after a miss is accepted until its final grant, `cpu_busy` and `bus_req` stay high with `bus_cmd` and `bus_addr` held stable while `bus_gnt` is low. `cpu_busy` falls in the cycle after completion.
- R13: While `snp_valid` is high, an idle controller does not act on a processor request: `cpu_done` stays low and no bus transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request word address; low bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_busy | output | 1 | A bus transaction for this cache is in flight |
| bus_req | output | 1 | Transaction request to the bus |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back or write data |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DATA_W | Line data returned with the grant |
| snp_valid | input | 1 | Another cache's transaction is observed |
| snp_cmd | input | 2 | Observed command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Observed address |
| flush_valid | output | 1 | Dirty data supplied in answer to a snoop |
| flush_addr | output | ADDR_W | Address of the flushed line |
| flush_data | output | DATA_W | Flushed data |

## Verification
The hardest case to reach is a dirty line that must be written back before a new miss. It needs a miss, then an upgrade or write that makes the slot Exclusive, then an access to a second tag that maps to the same index. The stimulus table orders its vectors so that this chain occurs for both a read and a write victim, and it checks both bus transactions and their order. Snoop-driven demotion and invalidation are then observed through the flush port and through whether the next processor access needs the bus. A held-off grant and a snoop that collides with a request cover stalling and deferral.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_SHD = 2'b01,
      LS_EXC = 2'b10
   } line_st_e;

   typedef enum logic [1:0] {
      BC_NONE   = 2'b00,
      BC_RDMISS = 2'b01,
      BC_WRMISS = 2'b10,
      BC_WBACK  = 2'b11
   } bus_cmd_e;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'b00,
      CS_EVICT = 2'b01,
      CS_MISS  = 2'b10
   } ctl_st_e;
endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
   import coh_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int IDX_W     = 2,
   parameter int TAG_W     = 6,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  a_idx,
   output line_st_e          a_st,
   output logic [TAG_W-1:0]  a_tag,
   output logic [DATA_W-1:0] a_data,
   input  logic [IDX_W-1:0]  b_idx,
   output line_st_e          b_st,
   output logic [TAG_W-1:0]  b_tag,
   output logic [DATA_W-1:0] b_data,
   input  logic              wa_en,
   input  logic [IDX_W-1:0]  wa_idx,
   input  line_st_e          wa_st,
   input  logic [TAG_W-1:0]  wa_tag,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              ws_en,
   input  logic [IDX_W-1:0]  ws_idx,
   input  line_st_e          ws_st
);
   line_st_e          st_all   [NUM_LINES];
   logic [TAG_W-1:0]  tag_all  [NUM_LINES];
   logic [DATA_W-1:0] data_all [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      line_st_e          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] data_r;

      // full-line write from the processor side beats a snoop state change
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r   <= LS_INV;
            tag_r  <= '0;
            data_r <= '0;
         end else if (wa_en && (wa_idx == IDX_W'(g))) begin
            st_r   <= wa_st;
            tag_r  <= wa_tag;
            data_r <= wa_data;
         end else if (ws_en && (ws_idx == IDX_W'(g))) begin
            st_r   <= ws_st;
         end
      end

      assign st_all[g]   = st_r;
      assign tag_all[g]  = tag_r;
      assign data_all[g] = data_r;
   end

   assign a_st   = st_all[a_idx];
   assign a_tag  = tag_all[a_idx];
   assign a_data = data_all[a_idx];
   assign b_st   = st_all[b_idx];
   assign b_tag  = tag_all[b_idx];
   assign b_data = data_all[b_idx];
endmodule

// File: rtl/coh_tag_match.sv
module coh_tag_match
   import coh_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  line_st_e         st,
   input  logic [TAG_W-1:0] line_tag,
   input  logic [TAG_W-1:0] req_tag,
   output logic             hit,
   output logic             hit_shd,
   output logic             hit_exc
);
   logic same;
   assign same    = (line_tag == req_tag);
   assign hit_shd = same && (st == LS_SHD);
   assign hit_exc = same && (st == LS_EXC);
   assign hit     = hit_shd || hit_exc;
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
   import coh_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              hit_shd,
   input  logic              hit_exc,
   input  logic [DATA_W-1:0] line_data,
   output logic              ws_en,
   output line_st_e          ws_st,
   output logic              flush_valid,
   output logic [ADDR_W-1:0] flush_addr,
   output logic [DATA_W-1:0] flush_data
);
   logic do_flush;

   always_comb begin
      ws_en    = 1'b0;
      ws_st    = LS_INV;
      do_flush = 1'b0;
      if (snp_valid) begin
         case (bus_cmd_e'(snp_cmd))
            BC_RDMISS: if (hit_exc) begin
               ws_en    = 1'b1;
               ws_st    = LS_SHD;
               do_flush = 1'b1;
            end
            BC_WRMISS: if (hit_exc || hit_shd) begin
               ws_en    = 1'b1;
               ws_st    = LS_INV;
               do_flush = hit_exc;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_valid <= 1'b0;
         flush_addr  <= '0;
         flush_data  <= '0;
      end else begin
         flush_valid <= do_flush;
         if (do_flush) begin
            flush_addr <= snp_addr;
            flush_data <= line_data;
         end
      end
   end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NUM_LINES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              cpu_busy,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              flush_valid,
   output logic [ADDR_W-1:0] flush_addr,
   output logic [DATA_W-1:0] flush_data
);
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int TAG_W = ADDR_W - IDX_W;

   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   ctl_st_e           st_q, st_d;
   logic [ADDR_W-1:0] req_addr_q, wb_addr_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q, wb_data_q;

   logic [IDX_W-1:0]  cpu_idx, snp_idx, req_idx;
   logic [TAG_W-1:0]  cpu_tag, snp_tag, req_tag;

   line_st_e          a_st, b_st;
   logic [TAG_W-1:0]  a_tag, b_tag;
   logic [DATA_W-1:0] a_data, b_data;
   logic              a_hit, a_shd, a_exc;
   logic              b_hit, b_shd, b_exc;

   logic              wa_en;
   logic [IDX_W-1:0]  wa_idx;
   line_st_e          wa_st;
   logic [TAG_W-1:0]  wa_tag;
   logic [DATA_W-1:0] wa_data;
   logic              ws_en;
   line_st_e          ws_st;

   logic take, rd_hit, wr_hit, upgrade, miss, evict, leave_idle;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snp_addr[IDX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
   assign req_idx = req_addr_q[IDX_W-1:0];
   assign req_tag = req_addr_q[ADDR_W-1:IDX_W];

   coh_line_array #(
      .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_lines (
      .clk(clk), .rst_n(rst_n),
      .a_idx(cpu_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
      .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
      .wa_en(wa_en), .wa_idx(wa_idx), .wa_st(wa_st), .wa_tag(wa_tag), .wa_data(wa_data),
      .ws_en(ws_en), .ws_idx(snp_idx), .ws_st(ws_st)
   );

   coh_tag_match #(.TAG_W(TAG_W)) u_cpu_match (
      .st(a_st), .line_tag(a_tag), .req_tag(cpu_tag),
      .hit(a_hit), .hit_shd(a_shd), .hit_exc(a_exc)
   );

   coh_tag_match #(.TAG_W(TAG_W)) u_snp_match (
      .st(b_st), .line_tag(b_tag), .req_tag(snp_tag),
      .hit(b_hit), .hit_shd(b_shd), .hit_exc(b_exc)
   );

   coh_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .hit_shd(b_shd), .hit_exc(b_exc), .line_data(b_data),
      .ws_en(ws_en), .ws_st(ws_st),
      .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data)
   );

   // processor lookup: only in idle, and only when no snoop claims the cycle
   assign take       = cpu_req && !snp_valid && (st_q == CS_IDLE);
   assign rd_hit     = take && !cpu_we && a_hit;
   assign wr_hit     = take && cpu_we && a_exc;
   assign upgrade    = take && cpu_we && a_shd;
   assign miss       = take && !a_hit;
   assign evict      = miss && (a_st == LS_EXC);
   assign leave_idle = miss || upgrade;

   always_comb begin
      st_d    = st_q;
      wa_en   = 1'b0;
      wa_idx  = cpu_idx;
      wa_st   = LS_INV;
      wa_tag  = cpu_tag;
      wa_data = cpu_wdata;
      case (st_q)
         CS_IDLE: begin
            if (wr_hit) begin
               wa_en = 1'b1;
               wa_st = LS_EXC;
            end else if (evict) begin
               wa_en   = 1'b1;
               wa_st   = LS_INV;
               wa_tag  = a_tag;
               wa_data = a_data;
               st_d    = CS_EVICT;
            end else if (leave_idle) begin
               st_d = CS_MISS;
            end
         end
         CS_EVICT: if (bus_gnt) st_d = CS_MISS;
         CS_MISS: if (bus_gnt) begin
            wa_en   = 1'b1;
            wa_idx  = req_idx;
            wa_tag  = req_tag;
            wa_st   = we_q ? LS_EXC : LS_SHD;
            wa_data = we_q ? wdata_q : bus_rdata;
            st_d    = CS_IDLE;
         end
         default: st_d = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CS_IDLE;
         req_addr_q <= '0;
         we_q       <= 1'b0;
         wdata_q    <= '0;
         wb_addr_q  <= '0;
         wb_data_q  <= '0;
      end else begin
         st_q <= st_d;
         if (leave_idle) begin
            req_addr_q <= cpu_addr;
            we_q       <= cpu_we;
            wdata_q    <= cpu_wdata;
            wb_addr_q  <= {a_tag, cpu_idx};
            wb_data_q  <= a_data;
         end
      end
   end

   assign cpu_busy  = (st_q != CS_IDLE);
   assign cpu_done  = rd_hit || wr_hit || ((st_q == CS_MISS) && bus_gnt);
   assign cpu_rdata = (st_q == CS_MISS) ? bus_rdata : a_data;
   assign bus_req   = cpu_busy;
   assign bus_cmd   = (st_q == CS_EVICT) ? BC_WBACK :
                      (st_q == CS_MISS)  ? (we_q ? BC_WRMISS : BC_RDMISS) : BC_NONE;
   assign bus_addr  = (st_q == CS_EVICT) ? wb_addr_q : req_addr_q;
   assign bus_wdata = (st_q == CS_EVICT) ? wb_data_q : (we_q ? wdata_q : '0);
endmodule

// File: rtl/snoop_coh_ctrl_chk.sv
module snoop_coh_ctrl_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NUM_LINES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_done,
   input logic              cpu_busy,
   input logic              bus_req,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_gnt,
   input logic              snp_valid,
   input logic [1:0]        snp_cmd,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              flush_valid,
   input logic [ADDR_W-1:0] flush_addr
);
   AST_DONE_ENDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && cpu_busy) |=> !cpu_busy); // R12

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R12

   AST_WBACK_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'b11 && bus_gnt) |=> (bus_req && (bus_cmd == 2'b01 || bus_cmd == 2'b10))); // R7

   AST_FLUSH_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> ($past(snp_valid) && ($past(snp_cmd) == 2'b01 || $past(snp_cmd) == 2'b10)
                       && flush_addr == $past(snp_addr))); // R9

   AST_SNOOP_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !cpu_busy) |-> !cpu_done); // R13

   AST_SNOOP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !cpu_busy) |=> !bus_req); // R13
endmodule

bind snoop_coh_ctrl snoop_coh_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)
) u_chk (.*);

// File: tb/snoop_coh_ctrl_test.sv
module snoop_coh_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0] cpu_addr = '0, cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       cpu_done, cpu_busy, bus_req;
   logic [1:0] bus_cmd;
   logic [7:0] bus_addr, bus_wdata;
   logic       bus_gnt = 1'b0;
   logic [7:0] bus_rdata = '0;
   logic       snp_valid = 1'b0;
   logic [1:0] snp_cmd = '0;
   logic [7:0] snp_addr = '0;
   logic       flush_valid;
   logic [7:0] flush_addr, flush_data;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   snoop_coh_ctrl #(.ADDR_W(8), .DATA_W(8), .NUM_LINES(4)) uut (.*);

   task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // results of the last access
   int         got_n;
   logic [1:0] got_cmd [2];
   logic [7:0] got_addr [2];
   logic [7:0] got_wd [2];
   logic [7:0] got_rd;

   task automatic access(input logic we, input logic [7:0] addr, input logic [7:0] wd, input logic [7:0] fill);
      logic fin;
      fin   = 1'b0;
      got_n = 0;
      got_rd = '0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      for (int cyc = 0; cyc < 40; cyc++) begin
         #1;
         if (bus_req) begin
            if (got_n < 2) begin
               got_cmd[got_n]  = bus_cmd;
               got_addr[got_n] = bus_addr;
               got_wd[got_n]   = bus_wdata;
            end
            got_n++;
            bus_gnt = 1'b1;
            bus_rdata = fill;
         end
         #1;
         if (cpu_done) begin
            got_rd = cpu_rdata;
            fin = 1'b1;
         end
         @(negedge clk);
         bus_gnt = 1'b0;
         if (fin) break;
      end
      cpu_req = 1'b0;
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr, input logic exp_fl,
                        input logic [7:0] exp_addr, input logic [7:0] exp_data, input string rq);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
      @(negedge clk);
      snp_valid = 1'b0;
      #1;
      check(rq, "flush_valid", flush_valid, exp_fl);
      if (exp_fl) begin
         check(rq, "flush_addr", flush_addr, exp_addr);
         check(rq, "flush_data", flush_data, exp_data);
      end
   endtask

   typedef struct packed {
      logic [3:0] rq;
      logic       we;
      logic [7:0] addr;
      logic [7:0] wd;
      logic [7:0] fill;
      logic [1:0] nbus;
      logic [1:0] c0;
      logic [1:0] c1;
      logic [7:0] rd;
      logic [7:0] wba;
      logic [7:0] wbd;
   } vec_t;

   // addresses: low 2 bits index, upper 6 bits tag
   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{4'd2, 1'b0, 8'h05, 8'h00, 8'hA1, 2'd1, 2'd1, 2'd0, 8'hA1, 8'h00, 8'h00}, // R2 cold read miss
      '{4'd3, 1'b0, 8'h05, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 8'hA1, 8'h00, 8'h00}, // R3 shared hit
      '{4'd5, 1'b1, 8'h05, 8'h33, 8'h00, 2'd1, 2'd2, 2'd0, 8'h00, 8'h00, 8'h00}, // R5 upgrade
      '{4'd4, 1'b1, 8'h05, 8'h44, 8'h00, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00}, // R4 exclusive write
      '{4'd4, 1'b0, 8'h05, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 8'h44, 8'h00, 8'h00}, // R4 value kept
      '{4'd7, 1'b0, 8'h09, 8'h00, 8'hB2, 2'd2, 2'd3, 2'd1, 8'hB2, 8'h05, 8'h44}, // R7 dirty victim, read
      '{4'd3, 1'b0, 8'h09, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 8'hB2, 8'h00, 8'h00}, // R3
      '{4'd6, 1'b1, 8'h0A, 8'h5C, 8'h00, 2'd1, 2'd2, 2'd0, 8'h00, 8'h00, 8'h00}, // R6 write miss
      '{4'd6, 1'b0, 8'h0A, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 8'h5C, 8'h00, 8'h00}, // R6 installed
      '{4'd7, 1'b1, 8'h06, 8'h61, 8'h00, 2'd2, 2'd3, 2'd2, 8'h00, 8'h0A, 8'h5C}, // R7 dirty victim, write
      '{4'd7, 1'b0, 8'h06, 8'h00, 8'h00, 2'd0, 2'd0, 2'd0, 8'h61, 8'h00, 8'h00}, // R7
      '{4'd7, 1'b0, 8'h0D, 8'h00, 8'hC3, 2'd1, 2'd1, 2'd0, 8'hC3, 8'h00, 8'h00}  // R7 clean victim
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "cpu_busy", cpu_busy, 1'b0);
      check("R1", "bus_req", bus_req, 1'b0);
      check("R1", "flush_valid", flush_valid, 1'b0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", TBL[i].rq, i);
         access(TBL[i].we, TBL[i].addr, TBL[i].wd, TBL[i].fill);
         check(tag, "bus transactions", got_n, TBL[i].nbus);
         if (TBL[i].nbus == 2'd2 && got_n == 2) begin
            check(tag, "wback cmd", got_cmd[0], TBL[i].c0);
            check(tag, "wback addr", got_addr[0], TBL[i].wba);
            check(tag, "wback data", got_wd[0], TBL[i].wbd);
            check(tag, "miss cmd", got_cmd[1], TBL[i].c1);
            check(tag, "miss addr", got_addr[1], TBL[i].addr);
         end else if (TBL[i].nbus == 2'd1 && got_n == 1) begin
            check(tag, "miss cmd", got_cmd[0], TBL[i].c0);
            check(tag, "miss addr", got_addr[0], TBL[i].addr);
         end
         if (!TBL[i].we) check(tag, "rdata", got_rd, TBL[i].rd);
      end
      // state now: idx1 0x0D Shared C3, idx2 0x06 Exclusive 61

      // R8: remote write miss invalidates a shared copy, no flush
      snoop(2'b10, 8'h0D, 1'b0, 8'h00, 8'h00, "R8");
      access(1'b0, 8'h0D, 8'h00, 8'hD4);
      check("R8", "refetch after invalidate", got_n, 1);
      check("R8", "refetch data", got_rd, 8'hD4);

      // R9: remote read miss to dirty line flushes and demotes
      snoop(2'b01, 8'h06, 1'b1, 8'h06, 8'h61, "R9");
      access(1'b0, 8'h06, 8'h00, 8'h00);
      check("R9", "read after demote is hit", got_n, 0);
      check("R9", "read after demote data", got_rd, 8'h61);
      access(1'b1, 8'h06, 8'h77, 8'h00);
      check("R9", "write after demote needs bus", got_n, 1);
      if (got_n == 1) check("R9", "write after demote cmd", got_cmd[0], 2'b10);

      // R10: remote write miss to dirty line flushes and invalidates
      snoop(2'b10, 8'h06, 1'b1, 8'h06, 8'h77, "R10");
      access(1'b0, 8'h06, 8'h00, 8'h88);
      check("R10", "read after invalidate misses", got_n, 1);
      check("R10", "read after invalidate data", got_rd, 8'h88);

      // R11: snoops that must not act (line 0x06 now Shared 88)
      snoop(2'b10, 8'h0E, 1'b0, 8'h00, 8'h00, "R11");
      snoop(2'b00, 8'h06, 1'b0, 8'h00, 8'h00, "R11");
      snoop(2'b11, 8'h06, 1'b0, 8'h00, 8'h00, "R11");
      snoop(2'b10, 8'h03, 1'b0, 8'h00, 8'h00, "R11");
      access(1'b0, 8'h06, 8'h00, 8'h00);
      check("R11", "line kept after ignored snoops", got_n, 0);
      check("R11", "data kept after ignored snoops", got_rd, 8'h88);

      // R12: stall with a held-off grant
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h07; cpu_wdata = 8'h7E;
      #1;
      check("R12", "no done on miss cycle", cpu_done, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         #1;
         check("R12", "busy while waiting", cpu_busy, 1'b1);
         check("R12", "bus_req while waiting", bus_req, 1'b1);
         check("R12", "cmd held", bus_cmd, 2'b10);
         check("R12", "addr held", bus_addr, 8'h07);
         check("R12", "no done without grant", cpu_done, 1'b0);
      end
      bus_gnt = 1'b1;
      #1;
      check("R12", "done with grant", cpu_done, 1'b1);
      @(negedge clk);
      bus_gnt = 1'b0; cpu_req = 1'b0;
      #1;
      check("R12", "busy falls after completion", cpu_busy, 1'b0);

      // R13: snoop in the same cycle defers a hit
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h07;
      snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = 8'h20;
      #1;
      check("R13", "hit deferred by snoop", cpu_done, 1'b0);
      @(negedge clk);
      snp_valid = 1'b0;
      #1;
      check("R13", "no bus after deferred hit", bus_req, 1'b0);
      check("R13", "hit served after snoop", cpu_done, 1'b1);
      check("R13", "hit data after snoop", cpu_rdata, 8'h7E);
      @(negedge clk);
      cpu_req = 1'b0;

      // R13: snoop in the same cycle defers a miss
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h24;
      snp_valid = 1'b1; snp_cmd = 2'b10; snp_addr = 8'h30;
      @(negedge clk);
      cpu_req = 1'b0; snp_valid = 1'b0;
      #1;
      check("R13", "no miss started under snoop", bus_req, 1'b0);
      check("R13", "not busy under snoop", cpu_busy, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule